// File: doc/BRIEF.md
# Integer Execute ALU with Immediate Operands

This block is the combinational integer execute stage of a small load/store processor core. It takes two 32-bit register operands, a 16-bit immediate, a 3-bit operation code and a flag that picks either the second register or the immediate as the second operand. It returns a 32-bit result and an overflow flag in the same cycle.

The block widens the immediate itself. Signed arithmetic sign-extends it. Unsigned arithmetic and the bitwise operations zero-extend it. A load-high operation places the immediate in the upper half of the result and fills the lower half with zeros. Only signed add and subtract can raise the overflow flag. The flag is a status output for the surrounding pipeline to act on. It does not trap.

Top module: `int_exec_alu`

## Requirements
- R1: The operation code `op_i` is decoded as 0=signed add, 1=unsigned add, 2=signed subtract, 3=unsigned subtract, 4=AND, 5=OR, 6=XOR, 7=load-high. Signed add returns `opa_i` plus the second operand, modulo 2^32. With all inputs at zero the result and overflow are both 0.
- R2: For signed add (0) and signed subtract (2), `ovf_o` is 1 exactly when the two's-complement result lies above 2^31-1 or below -2^31.
- R3: Unsigned add (1) and unsigned subtract (3) return the sum or difference modulo 2^32, and `ovf_o` stays 0 even when the operation carries or borrows.
- R4: When `use_imm_i`=1 and the operation is signed add or signed subtract, the immediate is sign-extended: bits 31:16 of the second operand copy `imm_i[15]`.
- R5: When `use_imm_i`=1 and the operation is unsigned add or unsigned subtract, the immediate is zero-extended.
- R6: When `use_imm_i`=0, AND, OR and XOR combine `opa_i` with `opb_i` bit by bit.
- R7: When `use_imm_i`=1, AND, OR and XOR combine `opa_i` with the zero-extended immediate, so bits 31:16 of an AND result are 0 and bits 31:16 of an OR or XOR result equal those of `opa_i`.
- R8: Load-high returns `imm_i` in bits 31:16 and zeros in bits 15:0, whatever the values of `opa_i`, `opb_i` and `use_imm_i`.
- R9: `ovf_o` is 0 for every operation code other than 0 and 2. When `use_imm_i`=1, `opb_i` has no effect on either output.
- R10: Signed subtract returns `opa_i` minus the second operand, modulo 2^32. This includes subtracting -2^31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| op_i | input | 3 | Operation code |
| use_imm_i | input | 1 | 1 selects the widened immediate as the second operand |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed arithmetic overflow |

## Verification
The bench builds the block with its default widths: a 32-bit datapath and a 16-bit immediate. These defaults put the real overflow edges within reach as literal operand values: 2^31-1 plus one, -2^31 minus one, and zero minus -2^31. An immediate of 0x8000 or 0xFFFF then shows whether the upper 16 bits were filled with the sign bit or with zeros. Directed corner cases are followed by a pseudo-random sweep over all eight operation codes in both operand modes.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDU = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBU = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_LHI  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN = 2'd0,
        EXT_ZERO = 2'd1
    } ext_mode_e;

    typedef struct packed {
        logic      is_sub;
        logic      is_signed;
        logic      is_logic;
        logic      is_high;
        ext_mode_e ext;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(alu_op_e op);
        op_ctrl_t c;
        c.is_sub    = (op == OP_SUB) || (op == OP_SUBU);
        c.is_signed = (op == OP_ADD) || (op == OP_SUB);
        c.is_logic  = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
        c.is_high   = (op == OP_LHI);
        c.ext       = c.is_signed ? EXT_SIGN : EXT_ZERO;
        return c;
    endfunction

endpackage

// File: rtl/int_exec_operand.sv
module int_exec_operand
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  ext_mode_e         ext,
    output logic [DATA_W-1:0] op2,
    output logic [DATA_W-1:0] high_word
);
    localparam int PAD = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_wide;

    always_comb begin
        if (ext == EXT_SIGN) imm_wide = {{PAD{imm[IMM_W-1]}}, imm};
        else                 imm_wide = {{PAD{1'b0}}, imm};
        op2       = use_imm ? imm_wide : reg_b;
        high_word = {imm, {PAD{1'b0}}};
    end

    // Widened bits must all follow the immediate's top bit in sign mode (R4), or be zero otherwise (R5)
    always_comb begin
        if (use_imm && ext == EXT_SIGN)
            assert_sign_fill_R4: assert ($countones(op2[DATA_W-1:IMM_W-1]) == 0 ||
                                         $countones(op2[DATA_W-1:IMM_W-1]) == PAD + 1);
        if (use_imm && ext == EXT_ZERO)
            assert_zero_fill_R5: assert ($countones(op2[DATA_W-1:IMM_W]) == 0);
    end
endmodule

// File: rtl/int_exec_addsub.sv
module int_exec_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf_raw
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wa, wb, wide;

    always_comb begin
        b_eff   = b ^ {DATA_W{is_sub}};
        sum     = a + b_eff + {{(DATA_W-1){1'b0}}, is_sub};
        ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

    // Cross-check with a one-bit-wider signed computation (R2)
    always_comb begin
        wa   = {a[MSB], a};
        wb   = {b[MSB], b};
        wide = is_sub ? (wa - wb) : (wa + wb);
        assert_ovf_range_R2: assert (ovf_raw == (wide[DATA_W] ^ wide[MSB]));
        assert_sum_low_R10: assert (sum == wide[MSB:0]);
    end
endmodule

// File: rtl/int_exec_logic.sv
module int_exec_logic
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] out
);
    always_comb begin
        case (op)
            OP_AND:  out = a & b;
            OP_OR:   out = a | b;
            default: out = a ^ b;
        endcase
    end

    // Algebraic properties of each bitwise operation (R6)
    always_comb begin
        if (op == OP_AND)
            assert_and_subset_R6: assert (((out & ~a) == '0) && ((out & ~b) == '0));
        if (op == OP_OR)
            assert_or_superset_R6: assert (((out & a) == a) && ((out & b) == b));
        if (op == OP_XOR)
            assert_xor_inverse_R6: assert ((out ^ a) == b);
    end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [2:0]        op_i,
    input  logic              use_imm_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ovf_o
);
    localparam int PAD = DATA_W - IMM_W;

    alu_op_e           op;
    op_ctrl_t          ctrl;
    logic [DATA_W-1:0] op2, high_word, sum, logic_out;
    logic              ovf_raw;

    always_comb begin
        op   = alu_op_e'(op_i);
        ctrl = decode_op(op);
    end

    int_exec_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
        .reg_b    (opb_i),
        .imm      (imm_i),
        .use_imm  (use_imm_i),
        .ext      (ctrl.ext),
        .op2      (op2),
        .high_word(high_word)
    );

    int_exec_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a      (opa_i),
        .b      (op2),
        .is_sub (ctrl.is_sub),
        .sum    (sum),
        .ovf_raw(ovf_raw)
    );

    int_exec_logic #(.DATA_W(DATA_W)) u_logic (
        .a  (opa_i),
        .b  (op2),
        .op (op),
        .out(logic_out)
    );

    always_comb begin
        if (ctrl.is_high)       result_o = high_word;
        else if (ctrl.is_logic) result_o = logic_out;
        else                    result_o = sum;
        ovf_o = ovf_raw & ctrl.is_signed;
    end

    // Port-level checks
    always_comb begin
        if (op_i == 3'd7)
            assert_load_high_R8: assert (result_o == {imm_i, {PAD{1'b0}}});
        if (op_i == 3'd1)
            assert_unsigned_sum_R3: assert ((result_o - opa_i) == op2);
        if (op_i != 3'd0 && op_i != 3'd2)
            assert_no_overflow_R9: assert (!ovf_o);
        if (op_i == 3'd4 && use_imm_i)
            assert_and_imm_high_R7: assert (result_o[DATA_W-1:IMM_W] == '0);
    end
endmodule

// File: tb/test_int_exec_alu.sv
module test_int_exec_alu;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opa, opb;
    logic [15:0] imm;
    logic [2:0]  op;
    logic        ui;
    logic [31:0] result;
    logic        ovf;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #5 clk = ~clk;

    int_exec_alu i_int_exec_alu (
        .opa_i(opa), .opb_i(opb), .imm_i(imm), .op_i(op),
        .use_imm_i(ui), .result_o(result), .ovf_o(ovf)
    );

    function automatic exp_t model(logic [2:0] o, logic [31:0] a, logic [31:0] b,
                                   logic [15:0] im, logic u, string tag);
        exp_t e;
        logic [31:0] sx, zx, s2, z2;
        longint w;
        sx = {{16{im[15]}}, im};
        zx = {16'h0, im};
        s2 = u ? sx : b;
        z2 = u ? zx : b;
        e.ovf = 1'b0;
        e.tag = tag;
        case (o)
            3'd0: begin
                e.res = a + s2;
                w = longint'($signed(a)) + longint'($signed(s2));
                e.ovf = (w > 64'sd2147483647) || (w < -64'sd2147483648);
            end
            3'd1: e.res = a + z2;
            3'd2: begin
                e.res = a - s2;
                w = longint'($signed(a)) - longint'($signed(s2));
                e.ovf = (w > 64'sd2147483647) || (w < -64'sd2147483648);
            end
            3'd3: e.res = a - z2;
            3'd4: e.res = a & z2;
            3'd5: e.res = a | z2;
            3'd6: e.res = a ^ z2;
            default: e.res = {im, 16'h0};
        endcase
        return e;
    endfunction

    task automatic drive(logic [2:0] o, logic [31:0] a, logic [31:0] b,
                         logic [15:0] im, logic u, string tag);
        @(negedge clk);
        op = o; opa = a; opb = b; imm = im; ui = u;
        q.push_back(model(o, a, b, im, u, tag));
    endtask

    // Monitor: compare at the edge after each vector is applied
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (result !== e.res || ovf !== e.ovf) begin
                n_bad++;
                $display("FAIL %s: got res=%h ovf=%b expected res=%h ovf=%b",
                         e.tag, result, ovf, e.res, e.ovf);
            end
        end
    end

    function automatic string op_tag(logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd2: return "R10";
            3'd1, 3'd3: return "R3";
            3'd7: return "R8";
            default: return "R6";
        endcase
    endfunction

    initial begin
        op = 3'd0; opa = '0; opb = '0; imm = '0; ui = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: idle state with all-zero inputs
        drive(3'd0, 32'h0, 32'h0, 16'h0, 1'b0, "R1");
        drive(3'd0, 32'd5, 32'd7, 16'h0, 1'b0, "R1");
        // R2: signed overflow boundaries
        drive(3'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 1'b0, "R2");
        drive(3'd0, 32'h80000000, 32'hFFFFFFFF, 16'h0, 1'b0, "R2");
        drive(3'd0, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b0, "R2");
        drive(3'd2, 32'h0, 32'h80000000, 16'h0, 1'b0, "R2");
        drive(3'd2, 32'h80000000, 32'h1, 16'h0, 1'b0, "R2");
        drive(3'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 1'b0, "R2");
        drive(3'd2, 32'hFFFFFFFF, 32'h80000000, 16'h0, 1'b0, "R2");
        // R10: subtraction results
        drive(3'd2, 32'd3, 32'd5, 16'h0, 1'b0, "R10");
        drive(3'd2, 32'h12345678, 32'h02345678, 16'h0, 1'b0, "R10");
        // R3: unsigned wrap, no overflow
        drive(3'd1, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b0, "R3");
        drive(3'd1, 32'h7FFFFFFF, 32'h1, 16'h0, 1'b0, "R3");
        drive(3'd3, 32'h0, 32'h1, 16'h0, 1'b0, "R3");
        drive(3'd3, 32'h80000000, 32'h1, 16'h0, 1'b0, "R3");
        // R4: sign-extended immediate
        drive(3'd0, 32'h0, 32'h0, 16'h8000, 1'b1, "R4");
        drive(3'd2, 32'd10, 32'h0, 16'hFFFF, 1'b1, "R4");
        drive(3'd0, 32'h7FFFFFFF, 32'h0, 16'h0001, 1'b1, "R4");
        drive(3'd0, 32'h80000000, 32'h0, 16'hFFFF, 1'b1, "R4");
        // R5: zero-extended immediate
        drive(3'd1, 32'h0, 32'h0, 16'h8000, 1'b1, "R5");
        drive(3'd3, 32'd10, 32'h0, 16'hFFFF, 1'b1, "R5");
        // R6: register-form bitwise
        drive(3'd4, 32'hF0F0_AAAA, 32'hFF00_5555, 16'h0, 1'b0, "R6");
        drive(3'd5, 32'hF0F0_AAAA, 32'hFF00_5555, 16'h0, 1'b0, "R6");
        drive(3'd6, 32'hF0F0_AAAA, 32'hFF00_5555, 16'h0, 1'b0, "R6");
        // R7: immediate-form bitwise with zero extension
        drive(3'd4, 32'hFFFFFFFF, 32'h0, 16'h8001, 1'b1, "R7");
        drive(3'd5, 32'h12340000, 32'h0, 16'h8001, 1'b1, "R7");
        drive(3'd6, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 1'b1, "R7");
        // R8: load-high ignores operands and mode
        drive(3'd7, 32'hDEADBEEF, 32'hCAFEF00D, 16'hA5C3, 1'b0, "R8");
        drive(3'd7, 32'h0, 32'hFFFFFFFF, 16'h8000, 1'b1, "R8");
        // R9: opb has no effect in immediate mode; no overflow on other codes
        drive(3'd0, 32'h7FFFFFFF, 32'h0, 16'h0001, 1'b1, "R9");
        drive(3'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0001, 1'b1, "R9");
        drive(3'd6, 32'h1234, 32'hAAAA5555, 16'h00FF, 1'b1, "R9");
        drive(3'd6, 32'h1234, 32'h5555AAAA, 16'h00FF, 1'b1, "R9");
        drive(3'd1, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'h0, 1'b0, "R9");
        // Pseudo-random sweep over all codes and both modes
        begin
            logic [31:0] s;
            s = 32'h1ACE_B00C;
            for (int i = 0; i < 400; i++) begin
                logic [31:0] a, b;
                s = s * 32'd1664525 + 32'd1013904223; a = s;
                s = s * 32'd1664525 + 32'd1013904223; b = s;
                drive(3'(i % 8), a, b, s[31:16], s[3], op_tag(3'(i % 8)));
            end
        end
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule